// File: doc/BRIEF.md
# Serial Game Controller Port Interface

This block sits between a simple synchronous CPU bus and two serial game controller ports. A write to the first of two adjacent port addresses sets a strobe line from bit 0 of the written byte. Both controllers share that strobe, and it holds its value until the next write to that address. Software raises the strobe to make the controllers load their buttons into their shift registers, then lowers it before it reads them out.

A read of either port address samples that port's five data lines and inverts them, so a low line reads as a 1. The inverted lines go onto the low five bits of the read data, and the upper three bits read as zero. The read also drives that port's clock output low for one cycle. The clock's return to high is the rising edge that shifts the next bit out of the controller. The data lines are captured on the read edge, before that rising edge occurs, so every read returns the bit that was present when the read happened.

Top module: `ctlport_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `port_strobe` is 0, both bits of `port_clk` are 1 and `bus_rdata` is 0x00.
- R2: A cycle with `bus_wr`=1 and `bus_addr`=`BASE_ADDR` (0x4016) loads `bus_wdata[0]` into `port_strobe`, visible from the next cycle. Bits 7:1 of the written byte are ignored, and the value holds until the next such write.
- R3: Writes to any other address, including `BASE_ADDR`+1 (0x4017), leave `port_strobe` unchanged.
- R4: A read (`bus_rd`=1) of `BASE_ADDR` drives `port_clk[0]` low in the following cycle only, while `port_clk[1]` stays high.
- R5: A read of `BASE_ADDR`+1 drives `port_clk[1]` low in the following cycle only, while `port_clk[0]` stays high.
- R6: A write cycle that has no read never drives either bit of `port_clk` low.
- R7: After a read of port p (p=0 for 0x4016, p=1 for 0x4017), `bus_rdata[i]` = NOT `port_din[5*p+i]` for i=0..4 from the next cycle.
- R8: Bits 7:5 of `bus_rdata` are 0 after every port read.
- R9: Cycles with no port read, including reads of other addresses, leave `bus_rdata` unchanged and both clocks high.
- R10: The data lines are sampled at the clock edge that ends the read cycle. Changes on `port_din` after that edge do not alter the returned value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | CPU read strobe for this cycle |
| bus_wr | input | 1 | CPU write strobe for this cycle |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data of the last port read, registered |
| port_strobe | output | 1 | Load strobe shared by both controllers |
| port_clk | output | 2 | Per-port shift clock, idle high |
| port_din | input | 10 | Data lines D0..D4 of port 0 (bits 4:0) and port 1 (bits 9:5) |

## Verification
The data lines are driven with all-zero, all-one and alternating patterns, plus a pseudo-random sequence. These patterns show whether the inversion, the bit order and the choice of port are correct. Reads of the two ports alternate and also come back to back, so a clock pulse that lands on the wrong port, or a data field taken from the wrong port, shows up. Writes to the strobe address, to its neighbour and to an unrelated address separate correct strobe latching from loose address decoding. The bench also changes the data lines just after a read, to confirm that sampling happens at the read edge.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
  localparam int CPU_DW    = 8;
  localparam int PAD_LINES = 5;

  typedef logic [CPU_DW-1:0]    cpu_byte_t;
  typedef logic [PAD_LINES-1:0] pad_lines_t;

  // Active-low pad lines become active-high data bits; upper bits read zero.
  function automatic cpu_byte_t pad_readback(input pad_lines_t lines);
    cpu_byte_t v;
    v = '0;
    v[PAD_LINES-1:0] = ~lines;
    return v;
  endfunction
endpackage

// File: rtl/ctlport_decode.sv
module ctlport_decode #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
  parameter int                NPORT     = 2
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [NPORT-1:0]  rd_hit,
  output logic              strobe_wr
);
  for (genvar g = 0; g < NPORT; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(BASE_ADDR + g);
    assign rd_hit[g] = bus_rd && (bus_addr == PORT_ADDR);
  end

  assign strobe_wr = bus_wr && (bus_addr == BASE_ADDR);

  always_comb begin
    assert ($onehot0(rd_hit)) else $error("p_single_hit_r4: more than one port hit");
  end
endmodule

// File: rtl/ctlport_strobe.sv
module ctlport_strobe (
  input  logic clk,
  input  logic rst,
  input  logic strobe_wr,
  input  logic wbit,
  output logic strobe_q
);
  always_ff @(posedge clk) begin
    if (rst)            strobe_q <= 1'b0;
    else if (strobe_wr) strobe_q <= wbit;
  end

  p_strobe_load_r2: assert property (@(posedge clk) disable iff (rst)
    strobe_wr |=> strobe_q == $past(wbit));
  p_strobe_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe_wr |=> $stable(strobe_q));
endmodule

// File: rtl/ctlport_clkgen.sv
module ctlport_clkgen #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] rd_hit,
  output logic [NPORT-1:0] port_clk
);
  for (genvar g = 0; g < NPORT; g++) begin : g_clk
    always_ff @(posedge clk) begin
      if (rst) port_clk[g] <= 1'b1;
      else     port_clk[g] <= ~rd_hit[g];
    end

    p_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
      rd_hit[g] |=> !port_clk[g]);
    p_clk_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !rd_hit[g] |=> port_clk[g]);
  end
endmodule

// File: rtl/ctlport_readmux.sv
module ctlport_readmux
  import ctlport_pkg::*;
#(
  parameter int NPORT = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NPORT-1:0]           rd_hit,
  input  logic [NPORT*PAD_LINES-1:0] pad_din,
  output cpu_byte_t                  rdata_q
);
  pad_lines_t sel_lines;
  logic       any_hit;

  always_comb begin
    sel_lines = '0;
    for (int p = 0; p < NPORT; p++)
      if (rd_hit[p]) sel_lines = pad_din[p*PAD_LINES +: PAD_LINES];
  end

  assign any_hit = |rd_hit;

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (any_hit) rdata_q <= pad_readback(sel_lines);
  end

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> rdata_q[CPU_DW-1:PAD_LINES] == '0);
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> $stable(rdata_q));
  p_data_invert_r7: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> rdata_q[PAD_LINES-1:0] == ~$past(sel_lines));
endmodule

// File: rtl/ctlport_if.sv
module ctlport_if
  import ctlport_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
  parameter int                NPORT     = 2,
  localparam int               DIN_W     = NPORT * PAD_LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CPU_DW-1:0] bus_wdata,
  output logic [CPU_DW-1:0] bus_rdata,
  output logic              port_strobe,
  output logic [NPORT-1:0]  port_clk,
  input  logic [DIN_W-1:0]  port_din
);
  logic [NPORT-1:0] rd_hit;
  logic             strobe_wr;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata[CPU_DW-1:1];

  ctlport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NPORT(NPORT)) u_decode (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_hit   (rd_hit),
    .strobe_wr(strobe_wr)
  );

  ctlport_strobe u_strobe (
    .clk      (clk),
    .rst      (rst),
    .strobe_wr(strobe_wr),
    .wbit     (bus_wdata[0]),
    .strobe_q (port_strobe)
  );

  ctlport_clkgen #(.NPORT(NPORT)) u_clkgen (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .port_clk(port_clk)
  );

  ctlport_readmux #(.NPORT(NPORT)) u_readmux (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .pad_din(port_din),
    .rdata_q(bus_rdata)
  );

  p_write_no_clk_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |=> port_clk == '1);
endmodule

// File: tb/tb_ctlport_if.sv
module tb_ctlport_if;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        port_strobe;
  logic [1:0]  port_clk;
  logic [9:0]  port_din;

  int total = 0;
  int bad   = 0;

  logic       m_strobe;
  logic [1:0] m_clk;
  logic [7:0] m_rdata;

  ctlport_if dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_strobe(port_strobe),
    .port_clk(port_clk), .port_din(port_din)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int port;
    if (rst) begin
      m_strobe = 1'b0; m_clk = 2'b11; m_rdata = 8'h00;
      return;
    end
    port = int'(bus_addr) - 'h4016;
    m_clk = 2'b11;
    if (bus_rd && (port == 0 || port == 1)) begin
      m_clk[port] = 1'b0;
      m_rdata = 8'h00;
      for (int b = 0; b < 5; b++)
        m_rdata[b] = (port_din[port*5 + b] == 1'b0);
    end
    if (bus_wr && port == 0) m_strobe = bus_wdata[0];
  endtask

  task automatic compare(input string tag);
    check(tag, "strobe", port_strobe, m_strobe);
    check(tag, "clk", port_clk, m_clk);
    check(tag, "rdata", bus_rdata, m_rdata);
  endtask

  // Drive at negedge, model at posedge, compare at next negedge.
  task automatic cyc(input string tag, input logic rd, input logic wr,
                     input logic [15:0] a, input logic [7:0] wd, input logic [9:0] din);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; port_din = din;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] lfsr;
    logic [7:0] held;
    rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; port_din = '1;
    m_strobe = 0; m_clk = 2'b11; m_rdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    cyc("R1", 0, 0, 16'h0000, 8'h00, 10'h3FF);

    // strobe latch
    cyc("R2", 0, 1, 16'h4016, 8'h01, 10'h3FF);
    check("R2", "strobe set", port_strobe, 1);
    cyc("R3", 0, 1, 16'h4017, 8'h00, 10'h3FF);
    check("R3", "strobe kept on 4017 write", port_strobe, 1);
    cyc("R3", 0, 1, 16'h4000, 8'h00, 10'h3FF);
    cyc("R2", 0, 1, 16'h4016, 8'hFE, 10'h3FF);
    check("R2", "bit0 only", port_strobe, 0);
    cyc("R6", 0, 1, 16'h4016, 8'h01, 10'h000);
    check("R6", "write no clk", port_clk, 2'b11);
    cyc("R2", 0, 1, 16'h4016, 8'h00, 10'h3FF);

    // port reads
    cyc("R4", 1, 0, 16'h4016, 8'h00, 10'b11111_10110);
    check("R4", "clk0 low only", port_clk, 2'b10);
    check("R7", "port0 data", bus_rdata, 8'h09);
    cyc("R9", 0, 0, 16'h0000, 8'h00, 10'h000);
    check("R9", "data held", bus_rdata, 8'h09);
    cyc("R5", 1, 0, 16'h4017, 8'h00, 10'b01010_11111);
    check("R5", "clk1 low only", port_clk, 2'b01);
    check("R7", "port1 data", bus_rdata, 8'h15);
    cyc("R7", 1, 0, 16'h4016, 8'h00, 10'h000);
    check("R8", "all low", bus_rdata, 8'h1F);
    cyc("R7", 1, 0, 16'h4017, 8'h00, 10'h3FF);
    check("R8", "all high", bus_rdata, 8'h00);
    cyc("R7", 1, 0, 16'h4017, 8'h00, 10'b00000_11111);
    check("R7", "port1 picked", bus_rdata, 8'h1F);

    // non-matching read
    cyc("R9", 1, 0, 16'h4018, 8'h00, 10'h000);
    check("R9", "no clk on other addr", port_clk, 2'b11);
    check("R9", "rdata held", bus_rdata, 8'h1F);

    // sampling point
    cyc("R10", 1, 0, 16'h4016, 8'h00, 10'b00000_01100);
    held = bus_rdata;
    cyc("R10", 0, 0, 16'h0000, 8'h00, 10'b00000_10011);
    check("R10", "value from read edge", bus_rdata, held);

    // read while strobe high and write same cycle
    cyc("R2", 1, 1, 16'h4016, 8'h01, 10'b00000_00001);

    // pseudo-random sweep
    lfsr = 10'h2A5;
    for (int k = 0; k < 60; k++) begin
      lfsr = {lfsr[8:0], lfsr[9] ^ lfsr[6]};
      cyc("R7", lfsr[0], lfsr[1] & ~lfsr[0], 16'h4016 + 16'(lfsr[3:2]), {7'h55, lfsr[4]}, lfsr);
      check("R8", "upper bits", int'(bus_rdata[7:5]), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule